// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses the direction of conditional branches for a five-stage pipeline. It holds a direct-mapped table of two-bit saturating counters with no tags. The word-address bits of the program counter select the entry, and several branches that land on the same entry share one counter. At fetch, the pipeline presents the PC, the branch offset and a flag that marks a conditional branch. In the same cycle the block answers with a predicted-taken bit and the next fetch address. The pipeline carries the predicted-taken bit down to execute.

When the branch resolves in execute, the pipeline presents the branch PC, its real direction, the bit predicted at fetch and the computed target. The block trains the indexed counter at the next clock edge. It also raises a flush, with the correct restart address, whenever the guess was wrong, whichever way it was wrong.

Counters are not reset directly. After reset the block sweeps the whole table, one entry per cycle, writing the weakly-not-taken value. A busy flag is high during the sweep.

Top module: `bdir_predictor`

## Requirements
- R1: The entry is selected by PC bits [IDX_W+1:2], where IDX_W = log2(DEPTH). PC bits [1:0] have no effect on which entry is read or trained.
- R2: After reset is released, init_busy stays high for exactly DEPTH clock edges. Every counter then holds 01 (weakly not taken), so every branch predicts not taken. While init_busy is high, fe_pred_taken is 0.
- R3: A resolved taken branch (ex_valid=1, ex_taken=1) increments the indexed counter at the next edge. A counter at 11 stays at 11.
- R4: A resolved not-taken branch decrements the indexed counter at the next edge. A counter at 00 stays at 00.
- R5: For a branch at fetch, fe_pred_taken equals bit 1 of the indexed counter. fe_next_pc is fe_pc+fe_offset when fe_pred_taken is 1, and fe_pc+4 when it is 0.
- R6: If a branch resolves taken but was predicted not taken, ex_flush is 1 and ex_redirect_pc equals ex_target in the same cycle.
- R7: If a branch resolves not taken but was predicted taken, ex_flush is 1 and ex_redirect_pc equals ex_pc+4 in the same cycle.
- R8: A resolved branch whose outcome matches its prediction, or a cycle with ex_valid=0, gives ex_flush=0 and ex_redirect_pc=0.
- R9: Two PCs whose index bits are equal but whose upper bits differ use and train the same counter.
- R10: When a lookup and an update address the same entry in one cycle, the lookup sees the counter value from before the update.
- R11: Resolve updates presented while init_busy is high leave the table unchanged. A fetch with fe_is_branch=0 gives fe_pred_taken=0 and fe_next_pc=fe_pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_is_branch | input | 1 | Fetched instruction is a conditional branch |
| fe_pc | input | XLEN | PC of the fetched instruction |
| fe_offset | input | XLEN | Branch offset of the fetched instruction |
| fe_pred_taken | output | 1 | Predicted taken |
| fe_next_pc | output | XLEN | Next fetch address |
| ex_valid | input | 1 | A branch resolves this cycle |
| ex_pc | input | XLEN | PC of the resolving branch |
| ex_taken | input | 1 | Actual outcome of the branch |
| ex_pred_taken | input | 1 | Predicted-taken bit carried from fetch |
| ex_target | input | XLEN | Computed taken target |
| ex_flush | output | 1 | Kill wrong-path instructions |
| ex_redirect_pc | output | XLEN | Restart address when flushing, else 0 |
| init_busy | output | 1 | Table initialisation sweep in progress |

## Verification
Fetch results and resolve results are combinational, so they are due in the cycle the inputs are applied. The bench drives inputs at the falling edge and samples them 1 ns later, before any rising edge can change the table. A counter change from a resolve shows up only at the rising edge that follows, so the bench observes training by a lookup of the same PC in a later cycle. That lookup is often presented in the same cycle as the next update, which also exercises the read-before-write rule. The length of the sweep is measured by counting rising edges from reset release until init_busy is seen low.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  localparam logic [1:0] CTR_STRONG_NT = 2'b00;
  localparam logic [1:0] CTR_WEAK_NT   = 2'b01;
  localparam logic [1:0] CTR_STRONG_T  = 2'b11;

  // Saturating step of a two-bit direction counter.
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bdp_sweep.sv
module bdp_sweep #(
  parameter int DEPTH = 2048,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;
  logic             step_en;

  assign step_en = busy_q;

  always_comb begin
    idx_d  = idx_q + 1'b1;
    busy_d = (idx_q != LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (step_en) begin
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  // R2: the sweep ends only after the last entry was written
  a_r2_sweep_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(idx_q) == LAST_IDX));

endmodule

// File: rtl/bdp_table.sv
module bdp_table
  import bdp_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [IDX_W-1:0] sweep_idx,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr
);
  logic [1:0]       ctr_mem [DEPTH];
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       wr_data;

  // The sweep owns the write port while busy; resolve updates are dropped.
  always_comb begin
    if (busy) begin
      wr_en   = 1'b1;
      wr_idx  = sweep_idx;
      wr_data = CTR_WEAK_NT;
    end else begin
      wr_en   = upd_en;
      wr_idx  = upd_idx;
      wr_data = ctr_step(ctr_mem[upd_idx], upd_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ctr_mem[wr_idx] <= wr_data;
  end

  // Read before write: the lookup sees the stored value.
  assign rd_ctr = ctr_mem[rd_idx];

  // R3: a write lands in storage at the next edge
  a_r3_ctr_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctr_mem[$past(wr_idx)] == $past(wr_data)));

  // R3: a taken update never lowers the counter
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && upd_en && upd_taken) |-> (wr_data >= ctr_mem[upd_idx]));

  // R4: a not-taken update never raises the counter
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && upd_en && !upd_taken) |-> (wr_data <= ctr_mem[upd_idx]));

endmodule

// File: rtl/bdp_fetch.sv
module bdp_fetch
  import bdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            busy,
  input  logic            is_branch,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] offset,
  input  logic [1:0]      ctr,
  output logic            pred_taken,
  output logic [XLEN-1:0] next_pc
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  always_comb begin
    pred_taken = is_branch && !busy && ctr_says_taken(ctr);
    next_pc    = pred_taken ? (pc + offset) : (pc + INSN_BYTES);
  end

endmodule

// File: rtl/bdp_resolve.sv
module bdp_resolve #(
  parameter int XLEN = 32
) (
  input  logic            valid,
  input  logic            taken,
  input  logic            pred_taken,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] target,
  output logic            flush,
  output logic [XLEN-1:0] redirect_pc
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  always_comb begin
    flush       = valid && (taken != pred_taken);
    redirect_pc = '0;
    if (flush) redirect_pc = taken ? target : (pc + INSN_BYTES);
  end

endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 2048
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fe_is_branch,
  input  logic [XLEN-1:0] fe_pc,
  input  logic [XLEN-1:0] fe_offset,
  output logic            fe_pred_taken,
  output logic [XLEN-1:0] fe_next_pc,
  input  logic            ex_valid,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_taken,
  input  logic            ex_pred_taken,
  input  logic [XLEN-1:0] ex_target,
  output logic            ex_flush,
  output logic [XLEN-1:0] ex_redirect_pc,
  output logic            init_busy
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] sweep_idx;
  logic [IDX_W-1:0] fe_idx, ex_idx;
  logic [1:0]       fe_ctr;

  assign fe_idx = fe_pc[IDX_W+1:2];
  assign ex_idx = ex_pc[IDX_W+1:2];

  bdp_sweep #(.DEPTH(DEPTH)) sweep_i (
    .clk(clk), .rst_n(rst_n), .busy_o(init_busy), .idx_o(sweep_idx)
  );

  bdp_table #(.DEPTH(DEPTH)) table_i (
    .clk(clk), .rst_n(rst_n), .busy(init_busy), .sweep_idx(sweep_idx),
    .upd_en(ex_valid), .upd_idx(ex_idx), .upd_taken(ex_taken),
    .rd_idx(fe_idx), .rd_ctr(fe_ctr)
  );

  bdp_fetch #(.XLEN(XLEN)) fetch_i (
    .busy(init_busy), .is_branch(fe_is_branch), .pc(fe_pc), .offset(fe_offset),
    .ctr(fe_ctr), .pred_taken(fe_pred_taken), .next_pc(fe_next_pc)
  );

  bdp_resolve #(.XLEN(XLEN)) resolve_i (
    .valid(ex_valid), .taken(ex_taken), .pred_taken(ex_pred_taken),
    .pc(ex_pc), .target(ex_target), .flush(ex_flush), .redirect_pc(ex_redirect_pc)
  );

  // R2: no taken guess while the table is being initialised
  a_r2_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !fe_pred_taken);

  // R5: a taken guess steers fetch to the branch target
  a_r5_target: assert property (@(posedge clk) disable iff (!rst_n)
    fe_pred_taken |-> (fe_next_pc == fe_pc + fe_offset));

  // R11: a non-branch is never predicted taken
  a_r11_nonbranch: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_is_branch |-> (!fe_pred_taken && fe_next_pc == fe_pc + XLEN'(4)));

  // R6: missed taken branch restarts at the target
  a_r6_missed_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_taken && !ex_pred_taken) |-> (ex_flush && ex_redirect_pc == ex_target));

  // R7: wrongly taken guess restarts at the fall-through
  a_r7_false_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_taken && ex_pred_taken) |-> (ex_flush && ex_redirect_pc == ex_pc + XLEN'(4)));

  // R8: a correct guess causes no flush
  a_r8_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid || ex_taken == ex_pred_taken) |-> (!ex_flush && ex_redirect_pc == '0));

endmodule

// File: tb/bdir_predictor_tb_top.sv
module bdir_predictor_tb_top;
  localparam int  XLEN  = 32;
  localparam int  DEPTH = 2048;
  localparam time CLK_P = 4ns;
  localparam logic [31:0] PC_A   = 32'h0000_0100;
  localparam logic [31:0] PC_AL  = PC_A + 32'(DEPTH * 4);
  localparam logic [31:0] PC_AB  = PC_A + 32'h3;
  localparam logic [31:0] PC_C   = 32'h0000_0104;
  localparam logic [31:0] OFFSET = 32'h0000_0040;
  localparam int NVEC = 13;
  // {pc, actual taken, expected prediction before the update}
  localparam logic [33:0] VEC [NVEC] = '{
    {PC_A,  1'b1, 1'b0}, {PC_A,  1'b1, 1'b1}, {PC_A,  1'b1, 1'b1},
    {PC_A,  1'b0, 1'b1}, {PC_A,  1'b0, 1'b1}, {PC_A,  1'b0, 1'b0},
    {PC_A,  1'b0, 1'b0}, {PC_A,  1'b1, 1'b0}, {PC_A,  1'b1, 1'b0},
    {PC_AL, 1'b0, 1'b1}, {PC_AB, 1'b1, 1'b0}, {PC_A,  1'b1, 1'b1},
    {PC_C,  1'b0, 1'b0}
  };

  logic            clk, rst_n;
  logic            fe_is_branch, fe_pred_taken, ex_valid, ex_taken, ex_pred_taken;
  logic            ex_flush, init_busy;
  logic [XLEN-1:0] fe_pc, fe_offset, fe_next_pc, ex_pc, ex_target, ex_redirect_pc;
  int checks, failures;
  bit done;

  bdir_predictor #(.XLEN(XLEN), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fe_is_branch(fe_is_branch), .fe_pc(fe_pc),
    .fe_offset(fe_offset), .fe_pred_taken(fe_pred_taken), .fe_next_pc(fe_next_pc),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_taken(ex_taken),
    .ex_pred_taken(ex_pred_taken), .ex_target(ex_target), .ex_flush(ex_flush),
    .ex_redirect_pc(ex_redirect_pc), .init_busy(init_busy)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fe_is_branch = 1'b0; fe_pc = '0; fe_offset = '0;
    ex_valid = 1'b0; ex_pc = '0; ex_taken = 1'b0; ex_pred_taken = 1'b0; ex_target = '0;
  endtask

  // Releases reset and returns the number of edges for which init_busy stayed high.
  task automatic reset_and_sweep(output int edges, input bit poke_late);
    edges = 0;
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R2 busy in reset", 32'(init_busy), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    fe_is_branch = 1'b1; fe_pc = PC_A; fe_offset = OFFSET;
    #1 chk("R2 no guess while busy", 32'(fe_pred_taken), 32'd0);
    forever begin
      @(posedge clk); edges++;
      #1;
      if (!init_busy) break;
      if (poke_late && edges >= DEPTH - 3) begin
        ex_valid = 1'b1; ex_pc = 32'h0; ex_taken = 1'b1; ex_pred_taken = 1'b0; ex_target = OFFSET;
      end
    end
    idle_inputs();
  endtask

  task automatic lookup(input logic [31:0] pc, input logic br, input logic exp_pred, input string req);
    @(negedge clk);
    idle_inputs();
    fe_is_branch = br; fe_pc = pc; fe_offset = OFFSET;
    #1;
    chk(req, 32'(fe_pred_taken), 32'(exp_pred));
    chk({req, " next pc"}, fe_next_pc, exp_pred ? pc + OFFSET : pc + 32'd4);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    #(CLK_P * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int edges;
    rst_n = 1'b1;
    idle_inputs();
    // R2 and R11: sweep length, updates during the sweep are dropped
    reset_and_sweep(edges, 1'b1);
    chk("R2 sweep length", 32'(edges), 32'(DEPTH));
    lookup(32'h0, 1'b1, 1'b0, "R11 update ignored while busy");
    lookup(PC_A, 1'b1, 1'b0, "R2 initial weak not taken");

    // Vector walk: lookup and update of the same entry in the same cycle (R10)
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] pc;
      logic        tk, ep;
      pc = VEC[i][33:2]; tk = VEC[i][1]; ep = VEC[i][0];
      @(negedge clk);
      fe_is_branch = 1'b1; fe_pc = pc; fe_offset = OFFSET;
      ex_valid = 1'b1; ex_pc = pc; ex_taken = tk; ex_pred_taken = ep; ex_target = pc + OFFSET;
      #1;
      // R3 R4 R5 R9 R1 R10: prediction follows the trained counter
      chk($sformatf("R3/R4/R5 vec%0d pred", i), 32'(fe_pred_taken), 32'(ep));
      chk($sformatf("R5 vec%0d next pc", i), fe_next_pc, ep ? pc + OFFSET : pc + 32'd4);
      chk($sformatf("R6/R7/R8 vec%0d flush", i), 32'(ex_flush), 32'(tk != ep));
      chk($sformatf("R6/R7/R8 vec%0d redirect", i), ex_redirect_pc,
          (tk == ep) ? 32'h0 : (tk ? pc + OFFSET : pc + 32'd4));
    end

    // R9: alias trained to strong taken through PC_A
    lookup(PC_AL, 1'b1, 1'b1, "R9 alias shares counter");
    // R1: byte bits ignored
    lookup(PC_AB, 1'b1, 1'b1, "R1 byte offset ignored");
    // R11: non-branch on a taken entry
    lookup(PC_A, 1'b0, 1'b0, "R11 non-branch not taken");
    // R8: idle resolve
    @(negedge clk); idle_inputs(); ex_pc = PC_A; ex_target = PC_A; #1;
    chk("R8 idle no flush", 32'(ex_flush), 32'd0);
    chk("R8 idle redirect zero", ex_redirect_pc, 32'h0);

    // R2: a second reset brings the entry back to weak not taken
    reset_and_sweep(edges, 1'b0);
    chk("R2 sweep length again", 32'(edges), 32'(DEPTH));
    lookup(PC_A, 1'b1, 1'b0, "R2 entry reinitialised");
    // R3: one taken update moves weak-not-taken to weak taken
    @(negedge clk); idle_inputs();
    ex_valid = 1'b1; ex_pc = PC_A; ex_taken = 1'b1; ex_pred_taken = 1'b0; ex_target = PC_A + OFFSET;
    #1 chk("R6 flush on missed taken", 32'(ex_flush), 32'd1);
    lookup(PC_A, 1'b1, 1'b1, "R3 increment after reinit");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule